// File: doc/BRIEF.md
# Sub-Dword Operand Select and Merge Unit

This block is one stage of a 32-bit integer datapath. Two source operands each have a field picked out of them: the whole dword, one of the four bytes, or one of the two 16-bit halves. Each picked field is widened to 32 bits, either with zeros or by copying its top bit. The two widened values are added. The sum is then cut down to the width of a destination field and placed into that field of the destination word.

Every destination bit outside the written field is filled by a policy. The policy can clear those bits, copy the field's sign bit above the field while clearing the bits below it, or keep the bits of the old destination value. An all-zero control word gives the plain case: full-dword sources, a full-dword destination and the keep policy.

The result is registered. It appears one clock after the input strobe, together with an output strobe.

Top module: `sdw_merge_unit`

## Requirements
- R1: A 3-bit field selector (`sel_a`, `sel_b`, `sel_d`) is decoded as follows: 0 is the full dword; 1, 2, 3 and 4 are bytes 0 to 3 at bit offsets 0, 8, 16 and 24; 5 is the low half (bits 15:0); 6 is the high half (bits 31:16). Encoding 7 behaves as the full dword.
- R2: When its sign flag (`sext_a`, `sext_b`) is 0, a byte or half field picked from a source is zero-extended to 32 bits.
- R3: When its sign flag is 1, a byte or half field picked from a source has its top bit copied into all higher bits. The flag has no effect when the full dword is selected.
- R4: The two extended operands are added modulo 2^32. Only the low bits of the sum that fit the destination field (8, 16 or 32) are written into that field.
- R5: When the destination selector picks the full dword, the output is the whole sum whatever the fill policy is.
- R6: With `pad_mode` = 1 (clear), every output bit outside the destination field is 0.
- R7: With `pad_mode` = 2 (sign), the output bits above the field equal the top bit of the written field, and the bits below the field are 0.
- R8: With `pad_mode` = 0 or 3 (keep), the output bits outside the field equal the same bits of `dst_old`.
- R9: `out_valid` is high in exactly the cycles that follow a clock edge at which `in_valid` was high. The matching result is on `out_data` in that same cycle.
- R10: Reset clears `out_valid` and `out_data`. A clock edge with `in_valid` low leaves `out_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| dst_old | input | 32 | Previous destination value |
| sel_a | input | 3 | Field selector for src_a |
| sel_b | input | 3 | Field selector for src_b |
| sel_d | input | 3 | Destination field selector |
| sext_a | input | 1 | Sign-extend the field picked from src_a |
| sext_b | input | 1 | Sign-extend the field picked from src_b |
| pad_mode | input | 2 | Fill policy for bits outside the destination field |
| out_valid | output | 1 | Output strobe |
| out_data | output | 32 | Merged result |

## Verification
Source sign extension and the destination sign-fill policy can act in the same cycle. In that case the bits filled above the destination field depend on a field top bit that itself came from the sign extension and the truncated sum. The bench provokes this with negative byte and half operands whose sum carries across the field boundary, with the sign policy and a narrow destination field. It compares every output against a bit-by-bit bench model of extension, addition and filling.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
   localparam int BYTE_W = 8;
   localparam int HALF_W = 16;
   localparam int FULL_W = 32;
   localparam int SEL_W  = 3;
   localparam int POL_W  = 2;
   localparam int SHF_W  = $clog2(FULL_W);

   typedef enum logic [SEL_W-1:0] {
      SEL_DWORD = 3'd0,
      SEL_BYTE0 = 3'd1,
      SEL_BYTE1 = 3'd2,
      SEL_BYTE2 = 3'd3,
      SEL_BYTE3 = 3'd4,
      SEL_HALF0 = 3'd5,
      SEL_HALF1 = 3'd6,
      SEL_RSVD  = 3'd7
   } field_sel_e;

   typedef enum logic [POL_W-1:0] {
      POL_KEEP     = 2'd0,
      POL_ZERO     = 2'd1,
      POL_SIGN     = 2'd2,
      POL_KEEP_ALT = 2'd3
   } fill_pol_e;

   typedef enum logic [1:0] {
      WC_BYTE = 2'd0,
      WC_HALF = 2'd1,
      WC_FULL = 2'd2
   } width_cls_e;

   typedef struct packed {
      width_cls_e        cls;
      logic [SHF_W-1:0]  lo;
   } field_t;

   function automatic field_t decode_field(input logic [SEL_W-1:0] s);
      field_t f;
      f.cls = WC_FULL;
      f.lo  = '0;
      case (field_sel_e'(s))
         SEL_BYTE0: begin f.cls = WC_BYTE; f.lo = SHF_W'(0 * BYTE_W); end
         SEL_BYTE1: begin f.cls = WC_BYTE; f.lo = SHF_W'(1 * BYTE_W); end
         SEL_BYTE2: begin f.cls = WC_BYTE; f.lo = SHF_W'(2 * BYTE_W); end
         SEL_BYTE3: begin f.cls = WC_BYTE; f.lo = SHF_W'(3 * BYTE_W); end
         SEL_HALF0: begin f.cls = WC_HALF; f.lo = SHF_W'(0); end
         SEL_HALF1: begin f.cls = WC_HALF; f.lo = SHF_W'(HALF_W); end
         default:   begin f.cls = WC_FULL; f.lo = '0; end
      endcase
      return f;
   endfunction
endpackage

// File: rtl/sdw_extract.sv
module sdw_extract
   import sdw_pkg::*;
#(
   parameter int DATA_W = FULL_W
) (
   input  logic [DATA_W-1:0] src,
   input  logic [SEL_W-1:0]  sel,
   input  logic              sext,
   output logic [DATA_W-1:0] val
);
   localparam int BW = BYTE_W;
   localparam int HW = HALF_W;

   if (DATA_W != FULL_W) begin : g_bad_width
      $error("sdw_extract: DATA_W must equal FULL_W");
   end

   field_t            fld;
   logic [DATA_W-1:0] shifted;
   logic              byte_top;
   logic              half_top;

   always_comb begin
      fld      = decode_field(sel);
      shifted  = src >> fld.lo;
      byte_top = sext & shifted[BW-1];
      half_top = sext & shifted[HW-1];
      case (fld.cls)
         WC_BYTE: val = {{(DATA_W-BW){byte_top}}, shifted[BW-1:0]};
         WC_HALF: val = {{(DATA_W-HW){half_top}}, shifted[HW-1:0]};
         default: val = shifted;
      endcase
   end
endmodule

// File: rtl/sdw_insert.sv
module sdw_insert
   import sdw_pkg::*;
#(
   parameter int DATA_W = FULL_W
) (
   input  logic [DATA_W-1:0] result,
   input  logic [DATA_W-1:0] old,
   input  logic [SEL_W-1:0]  sel,
   input  logic [POL_W-1:0]  pol,
   output logic [DATA_W-1:0] merged
);
   localparam int BW = BYTE_W;
   localparam int HW = HALF_W;
   localparam logic [DATA_W-1:0] BYTE_MASK = {{(DATA_W-BW){1'b0}}, {BW{1'b1}}};
   localparam logic [DATA_W-1:0] HALF_MASK = {{(DATA_W-HW){1'b0}}, {HW{1'b1}}};
   localparam logic [DATA_W-1:0] ONE       = {{(DATA_W-1){1'b0}}, 1'b1};

   if (DATA_W != FULL_W) begin : g_bad_width
      $error("sdw_insert: DATA_W must equal FULL_W");
   end

   field_t            fld;
   logic [DATA_W-1:0] base_mask;
   logic [DATA_W-1:0] fmask;
   logic [DATA_W-1:0] below;
   logic [DATA_W-1:0] above;
   logic [DATA_W-1:0] placed;
   logic [DATA_W-1:0] fill;
   logic              sign;

   always_comb begin
      fld = decode_field(sel);
      case (fld.cls)
         WC_BYTE: begin base_mask = BYTE_MASK; sign = result[BW-1];     end
         WC_HALF: begin base_mask = HALF_MASK; sign = result[HW-1];     end
         default: begin base_mask = '1;        sign = result[DATA_W-1]; end
      endcase
      fmask  = base_mask << fld.lo;
      below  = (ONE << fld.lo) - ONE;
      above  = ~(fmask | below);
      placed = (result << fld.lo) & fmask;
      case (fill_pol_e'(pol))
         POL_ZERO: fill = '0;
         POL_SIGN: fill = sign ? above : '0;
         default:  fill = old & ~fmask;
      endcase
      merged = placed | fill;
   end
endmodule

// File: rtl/sdw_merge_unit.sv
module sdw_merge_unit
   import sdw_pkg::*;
#(
   parameter int DATA_W = FULL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [DATA_W-1:0] dst_old,
   input  logic [2:0]        sel_a,
   input  logic [2:0]        sel_b,
   input  logic [2:0]        sel_d,
   input  logic              sext_a,
   input  logic              sext_b,
   input  logic [1:0]        pad_mode,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   localparam int NSRC = 2;

   if (DATA_W != FULL_W) begin : g_bad_width
      $error("sdw_merge_unit: DATA_W must equal FULL_W");
   end

   logic [DATA_W-1:0] src_v  [NSRC];
   logic [SEL_W-1:0]  sel_v  [NSRC];
   logic              sx_v   [NSRC];
   logic [DATA_W-1:0] ext_v  [NSRC];
   logic [DATA_W-1:0] sum;
   logic [DATA_W-1:0] merged;

   always_comb begin
      src_v[0] = src_a;  sel_v[0] = sel_a;  sx_v[0] = sext_a;
      src_v[1] = src_b;  sel_v[1] = sel_b;  sx_v[1] = sext_b;
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      sdw_extract #(.DATA_W(DATA_W)) u_ext (
         .src  (src_v[i]),
         .sel  (sel_v[i]),
         .sext (sx_v[i]),
         .val  (ext_v[i])
      );
   end

   assign sum = ext_v[0] + ext_v[1];

   sdw_insert #(.DATA_W(DATA_W)) u_ins (
      .result (sum),
      .old    (dst_old),
      .sel    (sel_d),
      .pol    (pad_mode),
      .merged (merged)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= merged;
      end
   end
endmodule

// File: rtl/sdw_merge_unit_chk.sv
module sdw_merge_unit_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] src_a,
   input logic [DATA_W-1:0] src_b,
   input logic [DATA_W-1:0] dst_old,
   input logic [2:0]        sel_a,
   input logic [2:0]        sel_b,
   input logic [2:0]        sel_d,
   input logic              sext_a,
   input logic              sext_b,
   input logic [1:0]        pad_mode,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data
);
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R9
   AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R9
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_data)); // R10
   AST_FULL_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sel_d == 3'd0 && sel_a == 3'd0 && sel_b == 3'd0) |=> out_data == $past(src_a + src_b)); // R5
   AST_KEEP_BYTE0: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sel_d == 3'd1 && pad_mode == 2'd0) |=> out_data[31:8] == $past(dst_old[31:8])); // R8
   AST_ZERO_HALF0: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sel_d == 3'd5 && pad_mode == 2'd1) |=> out_data[31:16] == 16'h0); // R6
   AST_SIGN_HALF1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sel_d == 3'd6 && pad_mode == 2'd2) |=> out_data[15:0] == 16'h0); // R7
endmodule

bind sdw_merge_unit sdw_merge_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sdw_merge_unit_test.sv
`timescale 1ns/1ps
module sdw_merge_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] src_a = '0, src_b = '0, dst_old = '0;
   logic [2:0]  sel_a = '0, sel_b = '0, sel_d = '0;
   logic        sext_a = 1'b0, sext_b = 1'b0;
   logic [1:0]  pad_mode = '0;
   logic        out_valid;
   logic [31:0] out_data;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   sdw_merge_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
      .sel_a(sel_a), .sel_b(sel_b), .sel_d(sel_d),
      .sext_a(sext_a), .sext_b(sext_b), .pad_mode(pad_mode),
      .out_valid(out_valid), .out_data(out_data)
   );

   function automatic void fld(input logic [2:0] s, output int lo, output int w);
      case (s)
         3'd1: begin lo = 0;  w = 8;  end
         3'd2: begin lo = 8;  w = 8;  end
         3'd3: begin lo = 16; w = 8;  end
         3'd4: begin lo = 24; w = 8;  end
         3'd5: begin lo = 0;  w = 16; end
         3'd6: begin lo = 16; w = 16; end
         default: begin lo = 0; w = 32; end
      endcase
   endfunction

   function automatic logic [31:0] m_ext(input logic [31:0] s, input logic [2:0] sel, input logic sx);
      int lo, w;
      logic [31:0] v;
      fld(sel, lo, w);
      v = '0;
      for (int i = 0; i < 32; i++) begin
         if (i < w) v[i] = s[lo+i];
         else v[i] = sx ? s[lo+w-1] : 1'b0;
      end
      return v;
   endfunction

   function automatic logic [31:0] m_ins(input logic [31:0] r, input logic [31:0] old,
                                         input logic [2:0] sel, input logic [1:0] pol);
      int lo, w;
      logic [31:0] v;
      fld(sel, lo, w);
      for (int i = 0; i < 32; i++) begin
         if (i >= lo && i < lo + w) v[i] = r[i-lo];
         else if (pol == 2'd1) v[i] = 1'b0;
         else if (pol == 2'd2) v[i] = (i >= lo + w) ? r[w-1] : 1'b0;
         else v[i] = old[i];
      end
      return v;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   // apply one operation, check result one cycle later
   task automatic op(input string tag, input logic [31:0] a, input logic [31:0] b, input logic [31:0] od,
                     input logic [2:0] sa, input logic [2:0] sb, input logic [2:0] sd,
                     input logic xa, input logic xb, input logic [1:0] pm);
      logic [31:0] exp;
      @(negedge clk);
      src_a = a; src_b = b; dst_old = od; sel_a = sa; sel_b = sb; sel_d = sd;
      sext_a = xa; sext_b = xb; pad_mode = pm; in_valid = 1'b1;
      exp = m_ins(m_ext(a, sa, xa) + m_ext(b, sb, xb), od, sd, pm);
      @(negedge clk);
      in_valid = 1'b0;
      check({tag, " R9 valid"}, {31'd0, out_valid}, 32'd1);
      check(tag, out_data, exp);
   endtask

   initial begin
      logic [31:0] held;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      check("R10 reset valid", {31'd0, out_valid}, 32'd0);
      check("R10 reset data", out_data, 32'd0);
      rst_n = 1'b1;

      op("R1 byte2 pick",  32'hA1B2C3D4, 0, 0, 3'd3, 3'd0, 3'd0, 0, 0, 2'd0);
      check("R1 byte2 literal", out_data, 32'h000000B2);
      op("R1 half1 pick",  32'h1234ABCD, 32'h0000FFFF, 0, 3'd6, 3'd5, 3'd0, 0, 0, 2'd1);
      check("R1 half sum literal", out_data, 32'h00011233);
      op("R1 code7 dword", 32'h80000001, 32'h1, 0, 3'd7, 3'd0, 3'd7, 1, 0, 2'd1);
      check("R1 code7 literal", out_data, 32'h80000002);
      op("R2 zero ext",    32'h00000080, 32'h00008000, 0, 3'd1, 3'd5, 3'd0, 0, 0, 2'd0);
      check("R2 zero literal", out_data, 32'h00008080);
      op("R3 sign ext",    32'hA1000000, 0, 0, 3'd4, 3'd0, 3'd0, 1, 0, 2'd0);
      check("R3 sign literal", out_data, 32'hFFFFFFA1);
      op("R3 dword noeff", 32'h7FFFFFFF, 32'h1, 0, 3'd0, 3'd0, 3'd0, 1, 1, 2'd2);
      check("R3 dword literal", out_data, 32'h80000000);
      op("R4 truncate",    32'h0000FFFF, 32'h1, 32'hDEADBEEF, 3'd5, 3'd0, 3'd5, 0, 0, 2'd0);
      check("R4 truncate literal", out_data, 32'hDEAD0000);
      op("R5 dword dest",  32'h12345678, 32'h11111111, 32'hFFFFFFFF, 3'd0, 3'd0, 3'd0, 0, 0, 2'd0);
      check("R5 literal", out_data, 32'h23456789);
      op("R6 pad",         32'h000000F0, 32'h00000020, 32'hFFFFFFFF, 3'd1, 3'd1, 3'd2, 0, 0, 2'd1);
      check("R6 literal", out_data, 32'h00001000);
      op("R7 sign fill",   32'h000000F0, 32'h00000001, 32'h12345678, 3'd1, 3'd1, 3'd2, 1, 1, 2'd2);
      check("R7 literal", out_data, 32'hFFFFF100);
      op("R7 carry cross", 32'h0000007F, 32'h00000001, 0, 3'd1, 3'd1, 3'd3, 1, 1, 2'd2);
      check("R7 carry literal", out_data, 32'hFF800000);
      op("R8 keep alt",    32'h00000005, 32'h00000003, 32'hCAFEBABE, 3'd1, 3'd1, 3'd3, 0, 0, 2'd3);
      check("R8 literal", out_data, 32'hCA08BABE);

      // R10: hold when strobe low
      held = out_data;
      @(negedge clk);
      src_a = $urandom; src_b = $urandom; dst_old = $urandom; sel_d = 3'd2; pad_mode = 2'd1;
      @(negedge clk);
      check("R10 hold data", out_data, held);
      check("R9 no strobe", {31'd0, out_valid}, 32'd0);

      for (int k = 0; k < 600; k++) begin
         logic [1:0] pm;
         string tg;
         pm = 2'($urandom_range(0, 3));
         tg = (pm == 2'd1) ? "R6 random" : (pm == 2'd2) ? "R7 random" : "R8 random";
         op(tg, $urandom, $urandom, $urandom,
            3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
            1'($urandom), 1'($urandom), pm);
      end

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule